// File: doc/BRIEF.md
# ADC-Range Automatic Gain Controller

This block regulates the analog front-end gain of a sampled receiver by watching how often the raw converter codes reach the edges of the input range. The samples arrive in groups of four, one group per carrier cycle. Each sample whose code sits at or beyond a programmable upper threshold, or at or below a programmable lower threshold, counts as one limit hit. The hits are summed over a window with a fixed number of groups. When the window closes, the sum is compared with two programmable targets.

The gain command is an unsigned duty-cycle value. It rises by one step when the window saw fewer hits than the lower target, and falls by one step when it saw more than the upper target. Inside the band it holds. The value stops at both of its ends.

The block also contains the pulse-width generator that this duty value drives. An external RC filter turns its pin into the control voltage of the analog gain element. The duty value itself is also brought out, so that the surrounding logic can read the current gain command.

Top module: `limitGainAgc`

## Requirements
- R1: During and right after reset the duty value equals the parameter DUTY_INIT, the window hit sum is zero and the pulse counter is zero.
- R2: A sample is a limit hit when its unsigned code is greater than or equal to `limitHigh`, or less than or equal to `limitLow`. A code exactly on a threshold is a hit; a code one step inside it is not. Each of the LANES samples in a group is tested independently, so one group adds 0 to LANES hits. Lane n occupies bits [n*SAMPLE_W +: SAMPLE_W] of `sampleGroup`.
- R3: Only groups presented with `sampleValid` high are counted. A window closes on exactly the WINDOW_GROUPS-th valid group. Data on the bus while `sampleValid` is low has no effect.
- R4: At window close, if the hit sum is less than `targetLow`, the duty value increases by one.
- R5: At window close, if the hit sum is at least `targetLow` and greater than `targetHigh`, the duty value decreases by one.
- R6: At window close, if the hit sum lies between `targetLow` and `targetHigh` inclusive, the duty value is unchanged.
- R7: The duty value saturates at 2^DUTY_W-1 and at 0 and never wraps.
- R8: The hits of the closing group belong to the window it closes. The next window starts from a sum of zero.
- R9: The duty value changes only on the clock edge that takes in a closing group, so the new value is visible one cycle later. At every other edge it holds.
- R10: The pulse counter is DUTY_W bits wide, runs freely with a period of 2^DUTY_W cycles and restarts at zero. `pwmOut` is high while the counter is below the duty value, so it is high for exactly duty cycles of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A new group of samples is present this cycle |
| sampleGroup | input | LANES*SAMPLE_W | Raw unsigned converter codes, lane 0 in the low bits |
| limitHigh | input | SAMPLE_W | Upper near-limit threshold (inclusive) |
| limitLow | input | SAMPLE_W | Lower near-limit threshold (inclusive) |
| targetLow | input | HIT_W = clog2(LANES*WINDOW_GROUPS+1) | Lower edge of the deadband on hits per window |
| targetHigh | input | HIT_W | Upper edge of the deadband on hits per window |
| gainDuty | output | DUTY_W | Current gain command (duty value) |
| pwmOut | output | 1 | Pulse-width modulated gain control pin |

## Verification
Two things can happen on the same clock edge: the hits of the window's last group are added to the sum, and the sum is evaluated and cleared. The test provokes this by putting every hit of a window into its closing group. It then checks that the step decision counts those hits. The window that follows carries no hits, and the test checks that the duty value rises, which shows that the sum started again from zero. Idle cycles between groups carry bus data full of limit codes. The duty value is checked after every group to confirm that those cycles and the non-closing groups leave it untouched.

// File: rtl/agcPkg.sv
package agcPkg;
  // Strobes from window control to the datapath
  typedef struct packed {
    logic accumulate;  // a valid group is present: add its hits
    logic close;       // this group ends the window: clear the sum
    logic stepUp;      // raise the duty value by one step
    logic stepDown;    // lower the duty value by one step
  } agcStrobe_t;
endpackage

// File: rtl/agcHitPath.sv
module agcHitPath
  import agcPkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int LANES     = 4,
  parameter int HIT_W     = 15,
  parameter int DUTY_W    = 10,
  parameter int DUTY_INIT = 512
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [LANES*SAMPLE_W-1:0] sampleGroup,
  input  logic [SAMPLE_W-1:0]       limitHigh,
  input  logic [SAMPLE_W-1:0]       limitLow,
  input  agcStrobe_t                strobe,
  output logic [HIT_W-1:0]          windowTotal,
  output logic [DUTY_W-1:0]         duty
);
  localparam int GH_W = $clog2(LANES + 1);
  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;
  localparam logic [DUTY_W-1:0] DUTY_RST = DUTY_W'(DUTY_INIT);

  logic [LANES-1:0] laneHit;
  logic [GH_W-1:0]  groupHits;
  logic [HIT_W-1:0] acc;

  // One near-limit comparator pair per lane
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [SAMPLE_W-1:0] code;
    assign code = sampleGroup[lane*SAMPLE_W +: SAMPLE_W];
    assign laneHit[lane] = (code >= limitHigh) || (code <= limitLow);
  end

  always_comb begin
    groupHits = '0;
    for (int i = 0; i < LANES; i++) begin
      groupHits = groupHits + GH_W'(laneHit[i]);
    end
  end

  // The sum seen at the close includes the closing group itself
  assign windowTotal = acc + HIT_W'(groupHits);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strobe.close) begin
      acc <= '0;
    end else if (strobe.accumulate) begin
      acc <= windowTotal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      duty <= DUTY_RST;
    end else if (strobe.stepUp && (duty != DUTY_MAX)) begin
      duty <= duty + 1'b1;
    end else if (strobe.stepDown && (duty != '0)) begin
      duty <= duty - 1'b1;
    end
  end

  assert_duty_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.close |=> $stable(duty));

  assert_top_sat_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepUp && duty == DUTY_MAX) |=> duty == DUTY_MAX);

  assert_bottom_sat_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDown && duty == '0) |=> duty == '0);

  assert_sum_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.close |=> acc == '0);
endmodule

// File: rtl/agcWindowCtl.sv
module agcWindowCtl
  import agcPkg::*;
#(
  parameter int WINDOW_GROUPS = 4096,
  parameter int HIT_W         = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [HIT_W-1:0] windowTotal,
  input  logic [HIT_W-1:0] targetLow,
  input  logic [HIT_W-1:0] targetHigh,
  output agcStrobe_t       strobe
);
  localparam int WIN_W = $clog2(WINDOW_GROUPS);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_GROUPS - 1);

  logic [WIN_W-1:0] winCnt;
  logic             lastGroup;
  logic             tooFew;
  logic             tooMany;

  assign lastGroup = (winCnt == WIN_LAST);
  assign tooFew    = windowTotal < targetLow;
  assign tooMany   = windowTotal > targetHigh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (sampleValid) begin
      winCnt <= lastGroup ? '0 : winCnt + 1'b1;
    end
  end

  // If the targets are crossed, raising the gain wins
  always_comb begin
    strobe.accumulate = sampleValid;
    strobe.close      = sampleValid && lastGroup;
    strobe.stepUp     = strobe.close && tooFew;
    strobe.stepDown   = strobe.close && !tooFew && tooMany;
  end

  assert_step_at_close_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepUp || strobe.stepDown) |-> (sampleValid && winCnt == WIN_LAST));

  assert_one_direction_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.stepUp, strobe.stepDown}));

  assert_count_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(winCnt));
endmodule

// File: rtl/agcPwmGen.sv
module agcPwmGen #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwmOut
);
  logic [DUTY_W-1:0] pwmCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwmCnt <= '0;
    end else begin
      pwmCnt <= pwmCnt + 1'b1;
    end
  end

  assign pwmOut = pwmCnt < duty;

  assert_pwm_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pwmCnt == '1) |=> (pwmCnt == '0));

  assert_pwm_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    (duty == '0) |-> !pwmOut);
endmodule

// File: rtl/limitGainAgc.sv
module limitGainAgc
  import agcPkg::*;
#(
  parameter int SAMPLE_W      = 12,
  parameter int LANES         = 4,
  parameter int DUTY_W        = 10,
  parameter int DUTY_INIT     = 512,
  parameter int WINDOW_GROUPS = 4096,
  localparam int HIT_W        = $clog2(LANES * WINDOW_GROUPS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleValid,
  input  logic [LANES*SAMPLE_W-1:0] sampleGroup,
  input  logic [SAMPLE_W-1:0]       limitHigh,
  input  logic [SAMPLE_W-1:0]       limitLow,
  input  logic [HIT_W-1:0]          targetLow,
  input  logic [HIT_W-1:0]          targetHigh,
  output logic [DUTY_W-1:0]         gainDuty,
  output logic                      pwmOut
);
  agcStrobe_t       strobe;
  logic [HIT_W-1:0] windowTotal;

  agcWindowCtl #(
    .WINDOW_GROUPS(WINDOW_GROUPS),
    .HIT_W        (HIT_W)
  ) ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .windowTotal(windowTotal),
    .targetLow  (targetLow),
    .targetHigh (targetHigh),
    .strobe     (strobe)
  );

  agcHitPath #(
    .SAMPLE_W (SAMPLE_W),
    .LANES    (LANES),
    .HIT_W    (HIT_W),
    .DUTY_W   (DUTY_W),
    .DUTY_INIT(DUTY_INIT)
  ) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleGroup(sampleGroup),
    .limitHigh  (limitHigh),
    .limitLow   (limitLow),
    .strobe     (strobe),
    .windowTotal(windowTotal),
    .duty       (gainDuty)
  );

  agcPwmGen #(
    .DUTY_W(DUTY_W)
  ) pwm_i (
    .clk   (clk),
    .rstN  (rstN),
    .duty  (gainDuty),
    .pwmOut(pwmOut)
  );
endmodule

// File: tb/limitGainAgc_tb_top.sv
module limitGainAgc_tb_top;
  localparam int SAMPLE_W = 12;
  localparam int LANES    = 4;
  localparam int DUTY_W   = 4;
  localparam int INIT     = 8;
  localparam int WIN      = 4;
  localparam int HIT_W    = $clog2(LANES * WIN + 1);
  localparam int DMAX     = (1 << DUTY_W) - 1;
  localparam int LIM_HI   = 4032;
  localparam int LIM_LO   = 63;
  localparam int TGT_LO   = 2;
  localparam int TGT_HI   = 5;

  // One window per entry: bit 12 = samples placed exactly on the thresholds,
  // bits [3g+2:3g] = number of hits in group g (group 0 is presented first)
  localparam logic [12:0] VEC [9] = '{
    {1'b0, 3'd0, 3'd0, 3'd0, 3'd0},   // 0 hits  -> up
    {1'b0, 3'd1, 3'd1, 3'd1, 3'd1},   // 4 hits  -> hold
    {1'b0, 3'd0, 3'd0, 3'd4, 3'd4},   // 8 hits  -> down
    {1'b1, 3'd2, 3'd0, 3'd0, 3'd0},   // 2 hits on exact thresholds -> hold
    {1'b0, 3'd4, 3'd0, 3'd0, 3'd1},   // 5 hits  -> hold
    {1'b0, 3'd0, 3'd1, 3'd0, 3'd0},   // 1 hit   -> up
    {1'b0, 3'd0, 3'd2, 3'd2, 3'd2},   // 6 hits  -> down
    {1'b1, 3'd4, 3'd0, 3'd0, 3'd0},   // all in closing group -> hold
    {1'b0, 3'd0, 3'd0, 3'd0, 3'd0}    // fresh window, 0 hits -> up
  };

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic                      sampleValid = 1'b0;
  logic [LANES*SAMPLE_W-1:0] sampleGroup = '0;
  logic [SAMPLE_W-1:0]       limitHigh = SAMPLE_W'(LIM_HI);
  logic [SAMPLE_W-1:0]       limitLow = SAMPLE_W'(LIM_LO);
  logic [HIT_W-1:0]          targetLow = HIT_W'(TGT_LO);
  logic [HIT_W-1:0]          targetHigh = HIT_W'(TGT_HI);
  logic [DUTY_W-1:0]         gainDuty;
  logic                      pwmOut;

  int  total = 0;
  int  bad = 0;
  int  expDuty = INIT;
  bit  finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  limitGainAgc #(
    .SAMPLE_W(SAMPLE_W), .LANES(LANES), .DUTY_W(DUTY_W),
    .DUTY_INIT(INIT), .WINDOW_GROUPS(WIN)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleGroup(sampleGroup),
    .limitHigh(limitHigh), .limitLow(limitLow), .targetLow(targetLow),
    .targetHigh(targetHigh), .gainDuty(gainDuty), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one valid group with a given number of hit lanes, then one idle
  // cycle whose bus data would be all hits if it were counted.
  task automatic sendGroup(input int hits, input bit onEdge);
    @(negedge clk);
    sampleValid = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      int code;
      if (l < hits) code = onEdge ? ((l % 2 == 0) ? LIM_HI : LIM_LO)
                                  : ((l % 2 == 0) ? 4095 : 0);
      else          code = onEdge ? ((l % 2 == 0) ? LIM_HI - 1 : LIM_LO + 1) : 2048;
      sampleGroup[l*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(code);
    end
    @(negedge clk);
    sampleValid = 1'b0;
    sampleGroup = '1;
  endtask

  task automatic runWindow(input logic [12:0] v);
    int sum = 0;
    string req;
    for (int g = 0; g < WIN; g++) begin
      int h = int'(v[g*3 +: 3]);
      sendGroup(h, v[12]);
      sum += h;
      if (g < WIN - 1)
        check("R9", "duty held inside window", int'(gainDuty), expDuty);
    end
    if (sum < TGT_LO) begin
      req = "R4";
      if (expDuty < DMAX) expDuty++;
    end else if (sum > TGT_HI) begin
      req = "R5";
      if (expDuty > 0) expDuty--;
    end else begin
      req = "R6";
    end
    check(req, "duty after window close", int'(gainDuty), expDuty);
  endtask

  task automatic measurePwm(input int exp);
    int high = 0;
    for (int c = 0; c < (1 << DUTY_W); c++) begin
      @(negedge clk);
      if (pwmOut) high++;
    end
    check("R10", "pwm high cycles per period", high, exp);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "duty in reset", int'(gainDuty), INIT);
    check("R1", "pwm in reset (counter zero)", int'(pwmOut), 1);
    rstN = 1'b1;

    // R2 R3 R4 R5 R6 R8 R9: table walk
    for (int i = 0; i < 9; i++) runWindow(VEC[i]);
    measurePwm(expDuty);

    // R7: saturate at the top
    for (int w = 0; w < DMAX + 2; w++) runWindow({1'b0, 12'd0});
    check("R7", "duty saturated high", int'(gainDuty), DMAX);
    measurePwm(DMAX);

    // R7: saturate at the bottom (16 hits per window)
    for (int w = 0; w < DMAX + 2; w++) runWindow({1'b0, 3'd4, 3'd4, 3'd4, 3'd4});
    check("R7", "duty saturated low", int'(gainDuty), 0);
    measurePwm(0);

    // R1: a new reset restores the initial duty
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "duty after second reset", int'(gainDuty), INIT);
    rstN = 1'b1;
    expDuty = INIT;
    runWindow({1'b0, 3'd0, 3'd0, 3'd3, 3'd0});
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule